// File: doc/BRIEF.md
# Linear-Mode CORDIC Fixed-Point Divider

The block divides a signed fixed-point dividend by a signed fixed-point divisor with shift-and-add iterations. Each iteration compares the sign of the running remainder with the sign of the divisor, steps the remainder toward zero by a shifted copy of the divisor, and adds or subtracts the matching power of two to a quotient accumulator. The divisor never changes, so it is only carried forward and never passes through an adder. Each addition is done as a single add: the operand is bit-inverted when needed, and the direction bit goes in as the carry.

All iterations are unrolled. A register bank sits after every `GRP`-th iteration and after the last one. The block accepts a new division on every clock. Two copies can run side by side to divide the real and imaginary parts of a complex value by a shared magnitude. A divisor of zero is only flagged; the quotient it produces has no meaning.

Inputs are two's complement with 3 integer and 25 fractional bits, 29 bits in all. The quotient is two's complement with 2 integer and 25 fractional bits, 28 bits in all. With the default `GRP` of 4, the 22 iterations fall into 6 register banks.

Top module: `cordic_lin_div`

## Requirements
- R1: For a divisor magnitude in [0.5, 4) and |dividend/divisor| <= 1.99, the quotient `out_q` (two's complement, LSB = 2^-25) differs from the true quotient by at most 2^-19, that is 64 LSB.
- R2: A sample presented with `in_valid` high is reported with `out_valid` high exactly 6 clock edges later. A new sample may be presented on every cycle, and results come out in the order they went in.
- R3: While `rst_n` is low, and afterwards until new valid input has travelled through, `out_valid` is low. Asserting reset discards every division still in flight.
- R4: `out_dz` is high with a result exactly when that sample's divisor was all zeros, and low for any non-zero divisor.
- R5: Every combination of dividend and divisor sign meets R1, and the quotient's sign follows the product of the input signs.
- R6: A dividend of zero with a non-zero divisor yields |`out_q`| <= 64 LSB.
- R7: The range limits meet R1: a ratio near ±1.99, a divisor of ±0.5, and a divisor just under 4.
- R8: For a non-zero divisor, a valid quotient always satisfies |`out_q`| < 2, so its two top bits agree.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | The operands on this cycle are a division to perform |
| in_y | input | 29 | Dividend, Q3.25 two's complement |
| in_x | input | 29 | Divisor, Q3.25 two's complement |
| out_valid | output | 1 | `out_q` and `out_dz` hold a result |
| out_q | output | 28 | Quotient, Q2.25 two's complement |
| out_dz | output | 1 | The divisor of this result was zero |

## Verification
The bench aims at the sign handling in all four quadrants. A design that took the direction from the wrong sign, or that swapped the carry polarity, would give a quotient of the wrong sign, or one off by a whole step. It drives ratios near ±1.99 and divisors at 0.5 and near 4, where a misplaced shift or a wrong starting weight shows up as a quotient that saturates near ±2 or drifts past the 64 LSB tolerance. A long back-to-back random stream and a reset in mid-flight expose a register bank placed in the wrong spot or a valid bit not cleared by reset: results arrive on the wrong cycle, or stale results appear. Zero dividends and zero divisors check the settle-to-zero case and the timing of the flag.

// File: rtl/cordic_lin_div.sv
`timescale 1ns/1ps
module cordic_lin_div #(
  parameter int XW     = 29,
  parameter int ZW     = 28,
  parameter int FRAC   = 25,
  parameter int STAGES = 22,
  parameter int GRP    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [XW-1:0] in_y,
  input  logic [XW-1:0] in_x,
  output logic          out_valid,
  output logic [ZW-1:0] out_q,
  output logic          out_dz
);
  localparam int LAT = (STAGES + GRP - 1) / GRP;

  logic signed [XW-1:0] ys [0:STAGES];
  logic signed [XW-1:0] xs [0:STAGES];
  logic signed [ZW-1:0] zs [0:STAGES];
  logic                 vs [0:STAGES];
  logic                 ds [0:STAGES];

  assign ys[0] = in_y;
  assign xs[0] = in_x;
  assign zs[0] = '0;
  assign vs[0] = in_valid;
  assign ds[0] = (in_x == '0);

  for (genvar k = 0; k < STAGES; k++) begin : g_it
    localparam logic [ZW-1:0] WT = ZW'(1) << (FRAC - k);
    logic signed [XW-1:0] xsh;
    logic                 up;
    logic [XW-1:0]        ynext;
    logic [ZW-1:0]        znext;

    assign xsh   = xs[k] >>> k;
    assign up    = ys[k][XW-1] ^ xs[k][XW-1];
    assign ynext = ys[k] + (up ? xsh : ~xsh) + {{(XW-1){1'b0}}, ~up};
    assign znext = zs[k] + (up ? ~WT : WT) + {{(ZW-1){1'b0}}, up};

    if (((k + 1) % GRP == 0) || (k == STAGES - 1)) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ys[k+1] <= '0;
          xs[k+1] <= '0;
          zs[k+1] <= '0;
          vs[k+1] <= 1'b0;
          ds[k+1] <= 1'b0;
        end else begin
          ys[k+1] <= ynext;
          xs[k+1] <= xs[k];
          zs[k+1] <= znext;
          vs[k+1] <= vs[k];
          ds[k+1] <= ds[k];
        end
      end
    end else begin : g_comb
      assign ys[k+1] = ynext;
      assign xs[k+1] = xs[k];
      assign zs[k+1] = znext;
      assign vs[k+1] = vs[k];
      assign ds[k+1] = ds[k];
    end
  end

  assign out_valid = vs[STAGES];
  assign out_q     = zs[STAGES];
  assign out_dz    = ds[STAGES];
endmodule

// File: rtl/cordic_lin_div_chk.sv
`timescale 1ns/1ps
module cordic_lin_div_chk #(
  parameter int XW  = 29,
  parameter int ZW  = 28,
  parameter int LAT = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [XW-1:0] in_x,
  input logic          out_valid,
  input logic [ZW-1:0] out_q,
  input logic          out_dz
);
  logic [LAT-1:0] vh, dh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vh <= '0;
      dh <= '0;
    end else begin
      vh <= {vh[LAT-2:0], in_valid};
      dh <= {dh[LAT-2:0], (in_x == '0)};
    end
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == vh[LAT-1]);

  assert_dz_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_dz == dh[LAT-1]));

  assert_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_dz) |-> (out_q[ZW-1] == out_q[ZW-2]));

  assert_known_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !$isunknown(out_q));
endmodule

bind cordic_lin_div cordic_lin_div_chk #(.XW(XW), .ZW(ZW), .LAT(LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x),
  .out_valid(out_valid), .out_q(out_q), .out_dz(out_dz)
);

// File: tb/cordic_lin_div_tb.sv
`timescale 1ns/1ps
module cordic_lin_div_tb;
  localparam int XW = 29, ZW = 28, FRAC = 25, LAT = 6;
  localparam longint TOL = 64;
  localparam longint ONE = 64'sd1 <<< FRAC;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [XW-1:0] in_y = '0, in_x = '0;
  logic out_valid, out_dz;
  logic [ZW-1:0] out_q;

  cordic_lin_div u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_y(in_y), .in_x(in_x),
    .out_valid(out_valid), .out_q(out_q), .out_dz(out_dz)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  longint q_exp[$];
  bit     q_dz[$];
  int     q_cyc[$];
  string  q_tag[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  task automatic push(input longint y, input longint x, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_y = y[XW-1:0];
    in_x = x[XW-1:0];
    q_dz.push_back(x == 0);
    q_exp.push_back(x == 0 ? 64'sd0 : (y <<< FRAC) / x);
    q_cyc.push_back(cyc);
    q_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q_exp.size() == 0) begin
        check(1'b0, "R3", "result with nothing in flight", 1, 0);
      end else begin
        longint e, a, d;
        bit     z;
        int     c;
        string  t;
        e = q_exp.pop_front();
        z = q_dz.pop_front();
        c = q_cyc.pop_front();
        t = q_tag.pop_front();
        check(cyc - c == LAT, "R2", "latency", cyc - c, LAT);
        check(out_dz == z, "R4", "divide-by-zero flag", out_dz, z);
        if (!z) begin
          a = longint'($signed(out_q));
          d = a - e;
          if (d < 0) d = -d;
          check(d <= TOL, t, "quotient", a, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (3) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R3", "valid during reset", out_valid, 0);
    end
    rst_n = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R3", "valid after reset", out_valid, 0);
    end

    push(ONE, ONE * 3 / 2, "R1");
    push(ONE * 5 / 4, ONE * 2, "R1");
    push(-ONE, ONE * 3 / 2, "R5");
    push(ONE, -ONE * 3 / 2, "R5");
    push(-ONE * 6 / 5, -ONE * 7 / 10, "R5");
    push(0, ONE * 5 / 4, "R6");
    push(0, -ONE * 3, "R6");
    push(ONE * 199 / 200, ONE / 2, "R7");
    push(-ONE * 199 / 200, ONE / 2, "R7");
    push(ONE * 199 / 200, -ONE / 2, "R7");
    push(ONE * 794 / 100, (ONE * 4) - 1, "R7");
    push(-ONE * 794 / 100, (ONE * 4) - 1, "R7");
    push(1, (ONE * 4) - 1, "R7");
    push(ONE * 3, 0, "R4");
    push(-ONE, 0, "R4");
    idle(LAT + 2);

    for (int i = 0; i < 400; i++) begin
      longint mx, my;
      mx = longint'($urandom_range((1 << 27) - 1, 1 << 24));
      my = longint'($urandom_range(32'(mx * 199 / 100), 0));
      if ($urandom_range(1, 0) == 1) mx = -mx;
      if ($urandom_range(1, 0) == 1) my = -my;
      push(my, mx, "R1");
    end
    idle(LAT + 4);
    check(q_exp.size() == 0, "R2", "results outstanding", q_exp.size(), 0);

    push(ONE, ONE, "R3");
    push(ONE, ONE, "R3");
    push(ONE, ONE, "R3");
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    q_exp.delete();
    q_dz.delete();
    q_cyc.delete();
    q_tag.delete();
    #1;
    check(out_valid == 1'b0, "R3", "valid cleared by reset", out_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (LAT + 3) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R3", "flushed work reappeared", out_valid, 0);
    end

    summary();
    $finish;
  end
endmodule